// File: doc/BRIEF.md
# Polled Real-Time-Clock Interrupt Emulator

This block rebuilds the three interrupt sources of a classic real-time clock (seconds update, time-of-day alarm and a divided periodic rate) from a single base tick at 64 Hz. A one-shot comparator channel outside the block fires when a free-running counter reaches the deadline that the block presents. On each firing the block moves the deadline forward, compares the supplied wall-clock time and advances a tick divider. When any source triggers, it issues a one-cycle interrupt strobe with a packed status word.

The comparator is never placed in a hardware periodic mode. After every tick the block re-arms it by adding the base interval to the deadline. If the counter has already passed the new deadline, the block keeps adding the interval, one step per clock cycle, until the deadline is ahead again. Each extra step counts as a missed tick, and the missed ticks are added to the periodic divider so that the periodic rate catches up. Software converts a requested periodic rate of 2 to 64 Hz into a divide limit of 64 divided by that rate. Keeping the calendar itself is the job of another block; this one only reads the current hour, minute and second.

Top module: `rtc_irq_emu`

## Requirements
- R1: While reset is applied and directly after it, the tick channel is disabled, the deadline is 0, the strobe is low, the status word is 0 and the lost-tick count is 0.
- R2: When at least one source enable becomes set and none was set in the previous cycle, the channel is enabled at the next clock edge and the deadline is loaded with counter plus interval.
- R3: When all three enables are clear, the channel is disabled at the next clock edge and ticks produce no strobe.
- R4: A tick on an enabled channel adds the interval to the deadline. If the deadline is then ahead of the counter, the strobe for that tick appears two clock edges after the edge that sampled the tick.
- R5: While the 32-bit signed difference counter minus deadline is greater than zero, the deadline is advanced by one interval per cycle and the step is counted as a lost tick. The comparison holds across counter wrap. The lost-tick output reports the count for the latest tick and saturates at 255. Each lost tick delays the strobe by one cycle.
- R6: With the update source enabled, a tick raises the update flag when the current seconds value differs from the recorded one. The recorded value then takes the current seconds. The recorded value is 0 after reset.
- R7: With the periodic source enabled, each tick adds one plus that tick's lost ticks to a count. When the count reaches or exceeds the divide limit, the periodic flag is raised and the count returns to 0.
- R8: With the alarm source enabled, a tick raises the alarm flag when hour, minute and second all equal the stored alarm time.
- R9: The status word is valid only in the single cycle of the strobe and is 0 otherwise. Its layout is: bit 4 update, bit 5 alarm, bit 6 periodic, bit 7 request (set with any flag), bits 15:8 equal to 1, and bits 3:0 equal to 0.
- R10: A tick that raises no flag produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Comparator fired (one-cycle pulse) |
| counter | input | 32 | Current value of the free-running counter |
| interval | input | 32 | Counter increments per base tick |
| en_update | input | 1 | Seconds-update source enable |
| en_alarm | input | 1 | Alarm source enable |
| en_periodic | input | 1 | Periodic source enable |
| cur_hour | input | 8 | Current hour |
| cur_min | input | 8 | Current minute |
| cur_sec | input | 8 | Current second |
| alm_hour | input | 8 | Alarm hour |
| alm_min | input | 8 | Alarm minute |
| alm_sec | input | 8 | Alarm second |
| per_limit | input | 14 | Periodic divide limit in base ticks |
| chan_en | output | 1 | Tick comparator channel enable |
| deadline | output | 32 | Comparator deadline value |
| irq_strobe | output | 1 | Interrupt strobe, one cycle |
| irq_status | output | 16 | Packed interrupt status word |
| lost_ticks | output | 8 | Missed ticks for the latest tick, saturating |

## Verification
The checker watches the following rules on every cycle: the shape of the status word, the single-cycle strobe, status being zero outside a strobe, shutdown of the channel once no enable is set, the deadline value at arming, and the rule that update and alarm flags only appear after their enables. The bench scenarios are needed to show the values that depend on history: the recorded-seconds comparison, the periodic divider including credit for lost ticks, the catch-up step count with its extra latency, saturation at 255, and the signed comparison across counter wrap.

// File: rtl/rtc_emu_pkg.sv
package rtc_emu_pkg;
   localparam int STATUS_W = 16;
   localparam logic [7:0] IRQ_COUNT = 8'd1;
   localparam int BIT_UPD = 4;
   localparam int BIT_ALM = 5;
   localparam int BIT_PER = 6;
   localparam int BIT_REQ = 7;

   typedef enum logic {
      TRK_IDLE,
      TRK_SEEK
   } trk_state_t;
endpackage

// File: rtl/rtc_deadline_tracker.sv
module rtc_deadline_tracker
   import rtc_emu_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int LOST_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              any_en,
   input  logic              tick,
   input  logic [CNT_W-1:0]  counter,
   input  logic [CNT_W-1:0]  interval,
   output logic              chan_en,
   output logic [CNT_W-1:0]  deadline,
   output logic              done,
   output logic [LOST_W-1:0] lost
);
   localparam logic [LOST_W-1:0] LOST_MAX = '1;

   trk_state_t        st;
   logic              any_en_q;
   logic [LOST_W-1:0] lost_run;
   logic [CNT_W-1:0]  gap;

   // signed distance from deadline to counter; positive means behind
   assign gap = counter - deadline;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= TRK_IDLE;
         any_en_q <= 1'b0;
         chan_en  <= 1'b0;
         deadline <= '0;
         done     <= 1'b0;
         lost     <= '0;
         lost_run <= '0;
      end else begin
         any_en_q <= any_en;
         done     <= 1'b0;
         if (!any_en) begin
            chan_en <= 1'b0;
            st      <= TRK_IDLE;
         end else if (!any_en_q) begin
            chan_en  <= 1'b1;
            deadline <= counter + interval;
            st       <= TRK_IDLE;
         end else begin
            case (st)
               TRK_IDLE: begin
                  if (tick && chan_en) begin
                     deadline <= deadline + interval;
                     lost_run <= '0;
                     st       <= TRK_SEEK;
                  end
               end
               TRK_SEEK: begin
                  if ($signed(gap) > 0) begin
                     deadline <= deadline + interval;
                     if (lost_run != LOST_MAX) lost_run <= lost_run + 1'b1;
                  end else begin
                     done <= 1'b1;
                     lost <= lost_run;
                     st   <= TRK_IDLE;
                  end
               end
               default: st <= TRK_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/rtc_flag_eval.sv
module rtc_flag_eval
   import rtc_emu_pkg::*;
#(
   parameter int TIME_W     = 8,
   parameter int PER_W      = 14,
   parameter int LOST_W     = 16,
   parameter int LOST_OUT_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  done,
   input  logic [LOST_W-1:0]     lost,
   input  logic                  en_update,
   input  logic                  en_alarm,
   input  logic                  en_periodic,
   input  logic [TIME_W-1:0]     cur_hour,
   input  logic [TIME_W-1:0]     cur_min,
   input  logic [TIME_W-1:0]     cur_sec,
   input  logic [TIME_W-1:0]     alm_hour,
   input  logic [TIME_W-1:0]     alm_min,
   input  logic [TIME_W-1:0]     alm_sec,
   input  logic [PER_W-1:0]      per_limit,
   output logic                  irq_strobe,
   output logic [STATUS_W-1:0]   irq_status,
   output logic [LOST_OUT_W-1:0] lost_ticks
);
   localparam int SUM_W = ((PER_W > LOST_W) ? PER_W : LOST_W) + 2;

   logic [TIME_W-1:0]     prev_sec;
   logic [PER_W-1:0]      per_cnt;
   logic [SUM_W-1:0]      per_sum;
   logic                  f_upd, f_alm, f_per, f_any;
   logic [LOST_OUT_W-1:0] lost_sat;

   assign per_sum = SUM_W'(per_cnt) + (en_periodic ? SUM_W'(lost) : '0) + SUM_W'(1);
   assign f_upd = en_update && (cur_sec != prev_sec);
   assign f_alm = en_alarm && (cur_hour == alm_hour) && (cur_min == alm_min)
                  && (cur_sec == alm_sec);
   assign f_per = en_periodic && (per_sum >= SUM_W'(per_limit));
   assign f_any = f_upd | f_alm | f_per;

   generate
      if (LOST_OUT_W >= LOST_W) begin : g_wide
         assign lost_sat = LOST_OUT_W'(lost);
      end else begin : g_sat
         localparam logic [LOST_OUT_W-1:0] SAT_MAX = '1;
         assign lost_sat = (lost > LOST_W'(SAT_MAX)) ? SAT_MAX : lost[LOST_OUT_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_sec   <= '0;
         per_cnt    <= '0;
         irq_strobe <= 1'b0;
         irq_status <= '0;
         lost_ticks <= '0;
      end else begin
         irq_strobe <= 1'b0;
         irq_status <= '0;
         if (done) begin
            lost_ticks <= lost_sat;
            if (f_upd) prev_sec <= cur_sec;
            if (en_periodic) per_cnt <= f_per ? '0 : per_sum[PER_W-1:0];
            if (f_any) begin
               irq_strobe          <= 1'b1;
               irq_status[15:8]    <= IRQ_COUNT;
               irq_status[BIT_REQ] <= 1'b1;
               irq_status[BIT_PER] <= f_per;
               irq_status[BIT_ALM] <= f_alm;
               irq_status[BIT_UPD] <= f_upd;
            end
         end
      end
   end
endmodule

// File: rtl/rtc_irq_emu.sv
module rtc_irq_emu
   import rtc_emu_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int TIME_W     = 8,
   parameter int PER_W      = 14,
   parameter int LOST_W     = 16,
   parameter int LOST_OUT_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick,
   input  logic [CNT_W-1:0]      counter,
   input  logic [CNT_W-1:0]      interval,
   input  logic                  en_update,
   input  logic                  en_alarm,
   input  logic                  en_periodic,
   input  logic [TIME_W-1:0]     cur_hour,
   input  logic [TIME_W-1:0]     cur_min,
   input  logic [TIME_W-1:0]     cur_sec,
   input  logic [TIME_W-1:0]     alm_hour,
   input  logic [TIME_W-1:0]     alm_min,
   input  logic [TIME_W-1:0]     alm_sec,
   input  logic [PER_W-1:0]      per_limit,
   output logic                  chan_en,
   output logic [CNT_W-1:0]      deadline,
   output logic                  irq_strobe,
   output logic [STATUS_W-1:0]   irq_status,
   output logic [LOST_OUT_W-1:0] lost_ticks
);
   generate
      if (CNT_W < 8)             begin : g_bad_cnt  $error("CNT_W too small");  end
      if (TIME_W < 6)            begin : g_bad_time $error("TIME_W too small"); end
      if (PER_W < 2)             begin : g_bad_per  $error("PER_W too small");  end
      if (LOST_W < LOST_OUT_W)   begin : g_bad_lost $error("LOST_W below output width"); end
   endgenerate

   logic              any_en;
   logic              trk_done;
   logic [LOST_W-1:0] trk_lost;

   assign any_en = en_update | en_alarm | en_periodic;

   rtc_deadline_tracker #(
      .CNT_W (CNT_W),
      .LOST_W(LOST_W)
   ) i_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .any_en  (any_en),
      .tick    (tick),
      .counter (counter),
      .interval(interval),
      .chan_en (chan_en),
      .deadline(deadline),
      .done    (trk_done),
      .lost    (trk_lost)
   );

   rtc_flag_eval #(
      .TIME_W    (TIME_W),
      .PER_W     (PER_W),
      .LOST_W    (LOST_W),
      .LOST_OUT_W(LOST_OUT_W)
   ) i_eval (
      .clk        (clk),
      .rst_n      (rst_n),
      .done       (trk_done),
      .lost       (trk_lost),
      .en_update  (en_update),
      .en_alarm   (en_alarm),
      .en_periodic(en_periodic),
      .cur_hour   (cur_hour),
      .cur_min    (cur_min),
      .cur_sec    (cur_sec),
      .alm_hour   (alm_hour),
      .alm_min    (alm_min),
      .alm_sec    (alm_sec),
      .per_limit  (per_limit),
      .irq_strobe (irq_strobe),
      .irq_status (irq_status),
      .lost_ticks (lost_ticks)
   );
endmodule

// File: rtl/rtc_irq_emu_chk.sv
module rtc_irq_emu_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_update,
   input logic             en_alarm,
   input logic             en_periodic,
   input logic [CNT_W-1:0] counter,
   input logic [CNT_W-1:0] interval,
   input logic             chan_en,
   input logic [CNT_W-1:0] deadline,
   input logic             irq_strobe,
   input logic [15:0]      irq_status
);
   p_single_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_strobe |=> !irq_strobe);

   p_status_form_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_strobe |-> (irq_status[7] && irq_status[15:8] == 8'd1
                      && irq_status[3:0] == 4'd0 && irq_status[6:4] != 3'd0));

   p_quiet_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_strobe |-> irq_status == 16'd0);

   p_chan_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_update || en_alarm || en_periodic) |=> !chan_en);

   p_arm_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_en) |-> deadline == $past(counter) + $past(interval));

   p_update_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_status[4] |-> $past(en_update));

   p_alarm_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_status[5] |-> $past(en_alarm));

   p_periodic_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_status[6] |-> $past(en_periodic));
endmodule

bind rtc_irq_emu rtc_irq_emu_chk #(.CNT_W(CNT_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en_update  (en_update),
   .en_alarm   (en_alarm),
   .en_periodic(en_periodic),
   .counter    (counter),
   .interval   (interval),
   .chan_en    (chan_en),
   .deadline   (deadline),
   .irq_strobe (irq_strobe),
   .irq_status (irq_status)
);

// File: tb/test_rtc_irq_emu.sv
module test_rtc_irq_emu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [31:0] counter = '0;
   logic [31:0] interval = '0;
   logic        en_update = 1'b0, en_alarm = 1'b0, en_periodic = 1'b0;
   logic [7:0]  cur_hour = '0, cur_min = '0, cur_sec = '0;
   logic [7:0]  alm_hour = '0, alm_min = '0, alm_sec = '0;
   logic [13:0] per_limit = '0;
   logic        chan_en;
   logic [31:0] deadline;
   logic        irq_strobe;
   logic [15:0] irq_status;
   logic [7:0]  lost_ticks;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] exp_dl;
   int          lat;
   logic [15:0] got_status;

   always #5 clk = ~clk;

   rtc_irq_emu i_rtc_irq_emu (
      .clk(clk), .rst_n(rst_n), .tick(tick), .counter(counter), .interval(interval),
      .en_update(en_update), .en_alarm(en_alarm), .en_periodic(en_periodic),
      .cur_hour(cur_hour), .cur_min(cur_min), .cur_sec(cur_sec),
      .alm_hour(alm_hour), .alm_min(alm_min), .alm_sec(alm_sec),
      .per_limit(per_limit), .chan_en(chan_en), .deadline(deadline),
      .irq_strobe(irq_strobe), .irq_status(irq_status), .lost_ticks(lost_ticks)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // pulse tick for one cycle, then wait for a strobe; lat = cycles after the tick edge
   task automatic fire_tick();
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      lat = 0;
      got_status = '0;
      for (int i = 1; i <= 400; i++) begin
         @(negedge clk);
         if (irq_strobe) begin
            lat = i;
            got_status = irq_status;
            break;
         end
      end
   endtask

   task automatic t_reset();
      check("R1 chan_en", 32'(chan_en), 0);
      check("R1 deadline", deadline, 0);
      check("R1 strobe", 32'(irq_strobe), 0);
      check("R1 status", 32'(irq_status), 0);
      check("R1 lost", 32'(lost_ticks), 0);
   endtask

   task automatic t_arm_and_update();
      @(negedge clk);
      counter = 1000; interval = 100; cur_sec = 5; en_update = 1'b1;
      @(negedge clk);
      exp_dl = 1100;
      check("R2 chan_en", 32'(chan_en), 1);
      check("R2 deadline", deadline, exp_dl);
      counter = exp_dl;
      fire_tick();
      exp_dl += 100;
      check("R4 latency", lat, 2);
      check("R4 deadline", deadline, exp_dl);
      check("R6 update status", 32'(got_status), 32'h0190);
      counter = exp_dl;
      fire_tick();
      exp_dl += 100;
      check("R10 no strobe same second", lat, 0);
      check("R6 recorded second replaced", 32'(got_status), 0);
      cur_sec = 6;
      counter = exp_dl;
      fire_tick();
      exp_dl += 100;
      check("R6 update on new second", 32'(got_status), 32'h0190);
   endtask

   task automatic t_alarm();
      cur_hour = 10; cur_min = 20;
      alm_hour = 10; alm_min = 20; alm_sec = 6;
      en_alarm = 1'b1;
      counter = exp_dl;
      fire_tick();
      exp_dl += 100;
      check("R8 alarm match", 32'(got_status), 32'h01A0);
      cur_min = 21;
      counter = exp_dl;
      fire_tick();
      exp_dl += 100;
      check("R8 alarm minute mismatch", lat, 0);
   endtask

   task automatic t_periodic();
      en_update = 1'b0; en_alarm = 1'b0; en_periodic = 1'b1; per_limit = 4;
      for (int k = 1; k <= 3; k++) begin
         counter = exp_dl;
         fire_tick();
         exp_dl += 100;
         check("R7 below limit", lat, 0);
      end
      counter = exp_dl;
      fire_tick();
      exp_dl += 100;
      check("R7 limit reached", 32'(got_status), 32'h01C0);
      check("R7 latency", lat, 2);
   endtask

   task automatic t_catch_up();
      per_limit = 3;
      counter = exp_dl + 250;
      fire_tick();
      exp_dl += 300;
      check("R5 latency with two lost", lat, 4);
      check("R5 deadline ahead", deadline, exp_dl);
      check("R5 lost count", 32'(lost_ticks), 2);
      check("R7 lost ticks credited", 32'(got_status), 32'h01C0);
   endtask

   task automatic t_saturate();
      interval = 1;
      counter = exp_dl + 300;
      fire_tick();
      exp_dl += 300;
      check("R5 long latency", lat, 301);
      check("R5 deadline after long seek", deadline, exp_dl);
      check("R5 lost saturates", 32'(lost_ticks), 255);
   endtask

   task automatic t_disable_and_wrap();
      @(negedge clk);
      en_periodic = 1'b0;
      @(negedge clk);
      check("R3 channel off", 32'(chan_en), 0);
      fire_tick();
      check("R3 tick ignored", lat, 0);
      counter = 32'hFFFF_FF00; interval = 32'h80; per_limit = 2; en_periodic = 1'b1;
      @(negedge clk);
      check("R2 rearm chan_en", 32'(chan_en), 1);
      check("R2 rearm deadline", deadline, 32'hFFFF_FF80);
      counter = 32'h10;
      fire_tick();
      check("R5 wrap latency", lat, 3);
      check("R5 wrap deadline", deadline, 32'h80);
      check("R5 wrap lost", 32'(lost_ticks), 1);
      check("R9 wrap status", 32'(got_status), 32'h01C0);
   endtask

   initial begin
      #1_500_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_arm_and_update();
      t_alarm();
      t_periodic();
      t_catch_up();
      t_saturate();
      t_disable_and_wrap();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule